// File: doc/BRIEF.md
# System Clock Control Register with Pin Gating

This block holds the settings that govern the chip-wide system clock and drives the external clock pin. A bus master writes one 8-bit control word at a fixed address. Three of its fields go to a separate divider: a 3-bit clock-select code and a scope bit for that divider. A pin-disable bit works together with the current power mode to decide what the clock pin does.

The clock pin is modelled as a data line plus an output enable, so that the pad can be released. In the running modes the pin either carries the system clock or is parked high. In the light standby mode it is parked high. In the deep standby mode the pin is released. The stored word survives the light standby mode and is wiped while the deep standby mode is active.

Top module: `clk_ctl_reg`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the stored word becomes 0x00, so a read at the register address returns 0x00.
- R2: A write with `bus_wr` high and `bus_addr` equal to 0xFF3A, outside deep standby, stores bits 7, 6, 5, 2, 1 and 0 of `bus_wdata` at the next rising edge. `bus_rdata` returns the stored word combinationally while `bus_addr` is 0xFF3A and returns 0x00 at any other address.
- R3: Bits 4 and 3 always read as 0, and writes to them are discarded.
- R4: A write to any address other than 0xFF3A leaves the stored word unchanged.
- R5: `clk_sel` equals stored bits 2:0 and `div_scope` equals stored bit 5.
- R6: `pwr_mode` is encoded as 00 normal, 01 sleep, 10 light standby and 11 deep standby. In normal or sleep mode with stored bit 7 at 0, `pin_oe` is 1 and `pin_data` follows `clk`.
- R7: In normal or sleep mode with stored bit 7 at 1, `pin_oe` is 1 and `pin_data` is held at 1.
- R8: In light standby, `pin_oe` is 1 and `pin_data` is 1 whatever bit 7 holds, and the stored word is retained.
- R9: In deep standby, `pin_oe` is 0, the stored word is cleared at every rising edge, and writes are ignored.
- R10: Bit 6 is reserved storage and reads back the value last written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it also feeds the clock pin |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Lower 16 bits of the bus address |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pwr_mode | input | 2 | Power mode: 00 normal, 01 sleep, 10 light standby, 11 deep standby |
| pin_data | output | 1 | Clock pin data |
| pin_oe | output | 1 | Clock pin output enable; 0 means high impedance |
| clk_sel | output | 3 | Clock-select code for the external divider |
| div_scope | output | 1 | Divider-scope bit for the external divider |

## Verification
The assertions assume that `pwr_mode`, `bus_wr`, `bus_addr` and `bus_wdata` are stable around each rising edge, so that their sampled values are the ones the register acts on. The stimulus meets this by changing every input on the falling edge only.

The pin-level checks in the assertions cover only the forced-high and released cases, because a value that follows the clock cannot be sampled meaningfully on that same clock. The stimulus therefore observes clock-following on the pin at mid-phase, in both the high and the low half of the clock.

// File: rtl/clkctl_pkg.sv
// Package: shared constants and types for the clock control register.
// Assumes an 8-bit register whose field positions are fixed by the divider
// and pin logic that decode them.
package clkctl_pkg;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned SEL_W    = 3;
    localparam int unsigned BIT_POFF = 7;   // pin-disable bit
    localparam int unsigned BIT_RSV  = 6;   // reserved storage bit
    localparam int unsigned BIT_SCOP = 5;   // divider-scope bit
    localparam int unsigned SEL_LSB  = 0;   // clock-select field base
    localparam logic [DATA_W-1:0] WR_MASK = 8'hE7;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'b00,
        PM_SLEEP  = 2'b01,
        PM_LSTBY  = 2'b10,
        PM_DSTBY  = 2'b11
    } pwr_mode_e;
endpackage

// File: rtl/clkctl_addr_dec.sv
// Module: address decoder and write qualifier.
// Produces the register select and a write enable that is suppressed while
// deep standby holds the register in clear.
module clkctl_addr_dec #(
    parameter int unsigned ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFF3A
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              deep,
    output logic              sel,
    output logic              we
);
    // Match the register address and qualify the write strobe.
    always_comb begin
        sel = (addr == REG_ADDR);
        we  = sel && wr && !deep;
    end
endmodule

// File: rtl/clkctl_regfile.sv
// Module: storage for the control word.
// Only the bits set in MASK have flops; the remaining bits are tied to 0.
// Assumes a synchronous active-low reset; deep standby acts as a clear.
module clkctl_regfile #(
    parameter int unsigned W = 8,
    parameter logic [W-1:0] MASK = 8'hE7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_ff
            // Hold one implemented bit; reset and clear dominate the write.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) q[i] <= 1'b0;
                else if (we)       q[i] <= wdata[i];
            end
        end else begin : g_tie
            assign q[i] = 1'b0;
        end
    end

    // R9
    hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));
    // R2
    wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr) |=> (q == ($past(wdata) & MASK)));
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && !clr) |=> $stable(q));
endmodule

// File: rtl/clkctl_pin_drv.sv
// Module: clock pin driver.
// Passes the system clock to the pin, parks the pin high, or releases it,
// depending on the power mode and the pin-disable bit. Purely combinational.
module clkctl_pin_drv
    import clkctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pwr_mode_e mode,
    input  logic      poff,
    output logic      pin_data,
    output logic      pin_oe
);
    logic running;

    // Choose the pin value and enable from the mode and disable bit.
    always_comb begin
        running  = (mode == PM_NORMAL) || (mode == PM_SLEEP);
        pin_oe   = (mode != PM_DSTBY);
        pin_data = (running && !poff) ? clk : 1'b1;
    end

    // R9
    hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_DSTBY) |-> !pin_oe);
    // R8
    lstby_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_LSTBY) |-> (pin_data && pin_oe));
    // R7
    off_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == PM_NORMAL || mode == PM_SLEEP) && poff) |-> (pin_data && pin_oe));
endmodule

// File: rtl/clk_ctl_reg.sv
// Module: top of the system clock control register.
// Joins the decoder, the storage and the pin driver, and exports the divider
// fields. Assumes bus inputs are stable around each rising clock edge.
module clk_ctl_reg
    import clkctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFF3A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [1:0]        pwr_mode,
    output logic              pin_data,
    output logic              pin_oe,
    output logic [2:0]        clk_sel,
    output logic              div_scope
);
    pwr_mode_e         mode;
    logic              deep, sel, we;
    logic [DATA_W-1:0] word;

    // Decode the raw mode bits into the shared enum.
    always_comb begin
        mode = pwr_mode_e'(pwr_mode);
        deep = (mode == PM_DSTBY);
    end

    clkctl_addr_dec #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
        .addr(bus_addr), .wr(bus_wr), .deep(deep), .sel(sel), .we(we)
    );

    clkctl_regfile #(.W(DATA_W), .MASK(WR_MASK)) u_reg (
        .clk(clk), .rst_n(rst_n), .clr(deep), .we(we),
        .wdata(bus_wdata), .q(word)
    );

    clkctl_pin_drv u_pin (
        .clk(clk), .rst_n(rst_n), .mode(mode), .poff(word[BIT_POFF]),
        .pin_data(pin_data), .pin_oe(pin_oe)
    );

    // Return read data and export the divider fields.
    always_comb begin
        bus_rdata = sel ? word : '0;
        clk_sel   = word[SEL_LSB +: SEL_W];
        div_scope = word[BIT_SCOP];
    end

    // R4
    miss_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!deep && !(bus_wr && bus_addr == REG_ADDR)) |=> $stable(word));
    // R3
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[4:3] == 2'b00);
endmodule

// File: tb/sim_clk_ctl_reg.sv
// Bench: sweeps all write values, all modes and the disable bit, and
// computes the expected values from the register's masking rules.
module sim_clk_ctl_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [1:0]  pwr_mode = 2'b00;
    logic        pin_data, pin_oe, div_scope;
    logic [2:0]  clk_sel;
    int n_chk = 0, n_bad = 0;
    localparam logic [15:0] RA = 16'hFF3A;

    always #5 clk = ~clk;

    clk_ctl_reg u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_mode(pwr_mode),
        .pin_data(pin_data), .pin_oe(pin_oe), .clk_sel(clk_sel),
        .div_scope(div_scope)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [15:0] a, logic [7:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    // Sample the pin in the low half and then in the high half of the clock.
    task automatic pin_chk(string req, logic oe_e, logic lo_e, logic hi_e);
        @(negedge clk); #2;
        check(req, {7'd0, pin_oe}, {7'd0, oe_e});
        check(req, {7'd0, pin_data}, {7'd0, lo_e});
        @(posedge clk); #2;
        check(req, {7'd0, pin_data}, {7'd0, hi_e});
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rd_chk("R1 reset", RA, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        // Sweep every write value: R2 R3 R5 R10.
        for (int v = 0; v < 256; v++) begin
            wr(RA, 8'(v));
            rd_chk("R2 readback", RA, 8'(v) & 8'hE7);
            check("R3 unimpl bits", {6'd0, bus_rdata[4:3]}, 8'h00);
            check("R10 reserved", {7'd0, bus_rdata[6]}, {7'd0, 1'(v >> 6)});
            check("R5 clk_sel", {5'd0, clk_sel}, 8'(v) & 8'h07);
            check("R5 div_scope", {7'd0, div_scope}, {7'd0, 1'(v >> 5)});
        end
        // Non-matching addresses: reads return 0, writes have no effect (R4).
        wr(RA, 8'h25);
        for (int k = 0; k < 16; k++) begin
            logic [15:0] a = RA ^ (16'h1 << k);
            wr(a, 8'hFF);
            rd_chk("R2 miss read", a, 8'h00);
            rd_chk("R4 miss write", RA, 8'h25);
        end
        // Pin behaviour over modes and disable bit: R6 R7 R8 R9.
        for (int p = 0; p < 2; p++) begin
            for (int m = 0; m < 3; m++) begin
                @(negedge clk); pwr_mode = 2'(m);
                wr(RA, p[0] ? 8'h80 : 8'h00);
                if (m == 2)        pin_chk("R8 lstby pin", 1'b1, 1'b1, 1'b1);
                else if (p == 1)   pin_chk("R7 parked high", 1'b1, 1'b1, 1'b1);
                else               pin_chk("R6 clock out", 1'b1, 1'b0, 1'b1);
            end
        end
        // Retention through light standby (R8).
        @(negedge clk); pwr_mode = 2'b00;
        wr(RA, 8'hC5);
        @(negedge clk); pwr_mode = 2'b10;
        repeat (5) @(negedge clk);
        pin_chk("R8 lstby pin bit7", 1'b1, 1'b1, 1'b1);
        pwr_mode = 2'b00;
        rd_chk("R8 retained", RA, 8'hC5);
        // Deep standby: release, clear, writes ignored (R9).
        @(negedge clk); pwr_mode = 2'b11;
        pin_chk("R9 release", 1'b0, 1'b1, 1'b1);
        rd_chk("R9 cleared", RA, 8'h00);
        wr(RA, 8'hA7);
        rd_chk("R9 write ignored", RA, 8'h00);
        @(negedge clk); pwr_mode = 2'b00;
        rd_chk("R9 after exit", RA, 8'h00);
        pin_chk("R6 clock resumes", 1'b1, 1'b0, 1'b1);
        // Reset mid-run clears (R1).
        wr(RA, 8'hE7);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd_chk("R1 reset clears", RA, 8'h00);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule